// File: doc/BRIEF.md
# Hybrid Column-Compression Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product in pure combinational logic. It has no clock, no reset and no state. The output follows any change on either operand after the settling delay of the logic.

Sixteen AND gates form the partial-product bits. Bit `a[i] & b[j]` carries weight `i+j`, and the bits are packed upward within each weight column. A three-stage compression tree then reduces the columns. In any column holding three or more bits, the tree places full adders greedily. Half adders appear in only two places: the lowest column that holds exactly two bits in a stage, and a column whose height has to be held to the stage target. Each adder's sum stays in its own column, and its carry moves one column up into the next stage.

After compression, weights 0 to 2 hold one bit each and pass straight to the output. Weights 3 to 6 are summed by a 4-bit ripple-carry adder, whose carry-out becomes product bit 7. The block is meant to sit inside a larger datapath as a small, low-area multiply unit.

Top module: `hybrid_mul`

## Requirements
- R1: For every one of the 256 operand pairs, `prod_o` equals the unsigned product `opa_i * opb_i`.
- R2: Product bit 0 equals `opa_i[0] & opb_i[0]` for every input.
- R3: When either operand is zero, all 8 product bits are zero.
- R4: When one operand is 1, the product equals the other operand, zero-extended to 8 bits.
- R5: The product never exceeds 225. Bit 7 is set exactly when the product is 128 or more, which makes it the carry-out of the final 4-bit adder.
- R6: The output depends only on the current operands. A new operand pair shows up on `prod_o` with no clock edge in between, and earlier inputs leave no trace.
- R7: When one operand is 2^k (k = 0..3), the product equals the other operand shifted left by k bit positions.
- R8: Swapping the two operands leaves the product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | Multiplier operand, unsigned |
| opb_i | input | 4 | Multiplicand operand, unsigned |
| prod_o | output | 8 | Unsigned product |

## Verification
The bound checker re-evaluates its checks on every operand change. It covers arithmetic equality with the product, the direct low bit, the zero and unit-operand cases, and the 225 upper bound (R1 to R5). Some properties involve two evaluations of the block, or the absence of a clock. Only the bench scenarios can show these: the commutative check (R8), the shift behaviour for power-of-two operands checked against a computed shift (R7), and a pair that changes between clock edges with no memory of the previous pair (R6). The bench also sweeps all 256 pairs against a product it computes itself.

// File: rtl/hybrid_mul_pkg.sv
package hybrid_mul_pkg;

    localparam int OP_W   = 4;
    localparam int PROD_W = 2 * OP_W;
    localparam int PP_N   = OP_W * OP_W;
    localparam int CPA_W  = 4;
    localparam int LOW_W  = PROD_W - CPA_W - 1;

    // Compressed operand rows handed to the final adder
    typedef struct packed {
        logic [CPA_W-1:0] row_x;
        logic [CPA_W-1:0] row_y;
        logic [LOW_W-1:0] low;
    } tree_out_t;

    // Flat index of partial product a[i] & b[j]
    function automatic int pp_idx(input int i, input int j);
        return i * OP_W + j;
    endfunction

endpackage

// File: rtl/hybrid_mul_fa.sv
module hybrid_mul_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic sum_o,
    output logic cry_o
);
    always_comb begin
        sum_o = x_i ^ y_i ^ z_i;
        cry_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    end
endmodule

// File: rtl/hybrid_mul_ha.sv
module hybrid_mul_ha (
    input  logic x_i,
    input  logic y_i,
    output logic sum_o,
    output logic cry_o
);
    always_comb begin
        sum_o = x_i ^ y_i;
        cry_o = x_i & y_i;
    end
endmodule

// File: rtl/hybrid_mul_ppgen.sv
module hybrid_mul_ppgen #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0]     opa_i,
    input  logic [B_W-1:0]     opb_i,
    output logic [A_W*B_W-1:0] pp_o
);
    for (genvar gi = 0; gi < A_W; gi++) begin : g_row
        for (genvar gj = 0; gj < B_W; gj++) begin : g_col
            assign pp_o[gi*B_W + gj] = opa_i[gi] & opb_i[gj];
        end
    end
endmodule

// File: rtl/hybrid_mul_tree.sv
// Three-stage column compression for the 4x4 array.
// Column heights before reduction (weight 0..6): 1 2 3 4 3 2 1
module hybrid_mul_tree
    import hybrid_mul_pkg::*;
(
    input  logic [PP_N-1:0] pp_i,
    output tree_out_t       tree_o
);
    logic p00, p01, p02, p03, p10, p11, p12, p13;
    logic p20, p21, p22, p23, p30, p31, p32, p33;

    always_comb begin
        p00 = pp_i[pp_idx(0,0)]; p01 = pp_i[pp_idx(0,1)];
        p02 = pp_i[pp_idx(0,2)]; p03 = pp_i[pp_idx(0,3)];
        p10 = pp_i[pp_idx(1,0)]; p11 = pp_i[pp_idx(1,1)];
        p12 = pp_i[pp_idx(1,2)]; p13 = pp_i[pp_idx(1,3)];
        p20 = pp_i[pp_idx(2,0)]; p21 = pp_i[pp_idx(2,1)];
        p22 = pp_i[pp_idx(2,2)]; p23 = pp_i[pp_idx(2,3)];
        p30 = pp_i[pp_idx(3,0)]; p31 = pp_i[pp_idx(3,1)];
        p32 = pp_i[pp_idx(3,2)]; p33 = pp_i[pp_idx(3,3)];
    end

    // Stage 1: HA on weight 1 (lowest two-bit column), FAs on weights 2,3,4
    logic s1_w1, c1_w2, s1_w2, c1_w3, s1_w3, c1_w4, s1_w4, c1_w5;
    hybrid_mul_ha st1_ha_w1 (.x_i(p01), .y_i(p10), .sum_o(s1_w1), .cry_o(c1_w2));
    hybrid_mul_fa st1_fa_w2 (.x_i(p02), .y_i(p11), .z_i(p20),
                             .sum_o(s1_w2), .cry_o(c1_w3));
    hybrid_mul_fa st1_fa_w3 (.x_i(p03), .y_i(p12), .z_i(p21),
                             .sum_o(s1_w3), .cry_o(c1_w4));
    hybrid_mul_fa st1_fa_w4 (.x_i(p13), .y_i(p22), .z_i(p31),
                             .sum_o(s1_w4), .cry_o(c1_w5));
    // Heights now: 1 1 2 3 2 3 1

    // Stage 2: HA on weight 2 (lowest two-bit column), FAs on weights 3 and 5
    logic s2_w2, c2_w3, s2_w3, c2_w4, s2_w5, c2_w6;
    hybrid_mul_ha st2_ha_w2 (.x_i(s1_w2), .y_i(c1_w2), .sum_o(s2_w2), .cry_o(c2_w3));
    hybrid_mul_fa st2_fa_w3 (.x_i(s1_w3), .y_i(p30), .z_i(c1_w3),
                             .sum_o(s2_w3), .cry_o(c2_w4));
    hybrid_mul_fa st2_fa_w5 (.x_i(p23), .y_i(p32), .z_i(c1_w5),
                             .sum_o(s2_w5), .cry_o(c2_w6));
    // Heights now: 1 1 1 2 3 1 2

    // Stage 3: FA on weight 4 only; no half adder needed
    logic s3_w4, c3_w5;
    hybrid_mul_fa st3_fa_w4 (.x_i(s1_w4), .y_i(c1_w4), .z_i(c2_w4),
                             .sum_o(s3_w4), .cry_o(c3_w5));
    // Heights now: 1 1 1 2 1 2 2 -> weights 3..6 go to the 4-bit adder

    always_comb begin
        tree_o.low   = {s2_w2, s1_w1, p00};
        tree_o.row_x = {p33,   s2_w5, s3_w4, s2_w3};
        tree_o.row_y = {c2_w6, c3_w5, 1'b0,  c2_w3};
    end
endmodule

// File: rtl/hybrid_mul_rca.sv
module hybrid_mul_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;

    for (genvar gk = 0; gk < W; gk++) begin : g_bit
        hybrid_mul_fa cell_i (
            .x_i  (x_i[gk]),
            .y_i  (y_i[gk]),
            .z_i  (chain[gk]),
            .sum_o(sum_o[gk]),
            .cry_o(chain[gk+1])
        );
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/hybrid_mul.sv
module hybrid_mul
    import hybrid_mul_pkg::*;
(
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [PROD_W-1:0] prod_o
);
    logic [PP_N-1:0]  pp_w;
    tree_out_t        tree_w;
    logic [CPA_W-1:0] cpa_sum_w;
    logic             cpa_cout_w;
    logic [PROD_W-1:0] prod_d;

    hybrid_mul_ppgen #(.A_W(OP_W), .B_W(OP_W)) ppgen_i (
        .opa_i(opa_i),
        .opb_i(opb_i),
        .pp_o (pp_w)
    );

    hybrid_mul_tree tree_i (
        .pp_i  (pp_w),
        .tree_o(tree_w)
    );

    hybrid_mul_rca #(.W(CPA_W)) cpa_i (
        .x_i   (tree_w.row_x),
        .y_i   (tree_w.row_y),
        .sum_o (cpa_sum_w),
        .cout_o(cpa_cout_w)
    );

    always_comb begin
        prod_d = {cpa_cout_w, cpa_sum_w, tree_w.low};
    end

    assign prod_o = prod_d;
endmodule

// File: rtl/hybrid_mul_chk.sv
module hybrid_mul_chk
    import hybrid_mul_pkg::*;
(
    input logic [OP_W-1:0]   opa_i,
    input logic [OP_W-1:0]   opb_i,
    input logic [PROD_W-1:0] prod_o
);
    logic [PROD_W-1:0] ref_prod;
    logic [PROD_W-1:0] max_prod;

    always_comb begin
        ref_prod = PROD_W'(opa_i) * PROD_W'(opb_i);
        max_prod = PROD_W'({OP_W{1'b1}}) * PROD_W'({OP_W{1'b1}});
        assert_product_R1: assert (prod_o == ref_prod)
            else $error("R1 product %0d for %0d*%0d", prod_o, opa_i, opb_i);
        assert_low_bit_R2: assert (prod_o[0] == (opa_i[0] & opb_i[0]))
            else $error("R2 low bit mismatch");
        assert_zero_R3: assert (!((opa_i == '0) || (opb_i == '0)) || (prod_o == '0))
            else $error("R3 nonzero product for zero operand");
        assert_unit_R4: assert (!(opa_i == OP_W'(1)) || (prod_o == PROD_W'(opb_i)))
            else $error("R4 unit operand mismatch");
        assert_bound_R5: assert (prod_o <= max_prod)
            else $error("R5 product above bound");
    end
endmodule

bind hybrid_mul hybrid_mul_chk chk_i (
    .opa_i (opa_i),
    .opb_i (opb_i),
    .prod_o(prod_o)
);

// File: tb/hybrid_mul_tb.sv
module hybrid_mul_tb_top;
    logic       clk;
    logic       rst_n;
    logic [3:0] opa;
    logic [3:0] opb;
    logic [7:0] prod;
    int         n_run;
    int         n_fail;
    bit         done;

    hybrid_mul dut_i (
        .opa_i (opa),
        .opb_i (opb),
        .prod_o(prod)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opa, opb, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        opa = a;
        opb = b;
        #2;
    endtask

    initial begin
        n_run  = 0;
        n_fail = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        opa    = '0;
        opb    = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R3 reset-state zero inputs", prod, 8'd0);

        // Exhaustive sweep: R1, R2, R3, R4, R5
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                apply(4'(ia), 4'(ib));
                check("R1 exhaustive", prod, 8'(ia * ib));
                check("R2 low bit", {7'd0, prod[0]}, {7'd0, 1'(ia & ib & 1)});
                if (ia == 0 || ib == 0) check("R3 zero operand", prod, 8'd0);
                if (ia == 1) check("R4 unit operand", prod, 8'(ib));
                if (ib == 1) check("R4 unit operand", prod, 8'(ia));
                check("R5 bit7 carry-out", {7'd0, prod[7]}, {7'd0, 1'((ia * ib) >= 128)});
                if (prod > 8'd225) check("R5 upper bound", prod, 8'd225);
            end
        end

        // R7: power-of-two operand gives a shift
        for (int k = 0; k < 4; k++) begin
            for (int ib = 0; ib < 16; ib++) begin
                apply(4'(1 << k), 4'(ib));
                check("R7 shift", prod, 8'(ib) << k);
            end
        end

        // R8: commutativity
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                logic [7:0] first;
                apply(4'(ia), 4'(ib));
                first = prod;
                apply(4'(ib), 4'(ia));
                check("R8 swapped operands", prod, first);
            end
        end

        // R6: changes between clock edges, no memory of the previous pair
        @(negedge clk);
        opa = 4'd15; opb = 4'd15;
        #2 check("R6 settle without clock", prod, 8'd225);
        opa = 4'd3;  opb = 4'd5;
        #2 check("R6 settle without clock", prod, 8'd15);
        opa = 4'd0;
        #2 check("R6 no trace of earlier pair", prod, 8'd0);
        opa = 4'd9;  opb = 4'd14;
        #2 check("R6 settle without clock", prod, 8'd126);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule